// File: doc/BRIEF.md
# 625-Line Interlaced Digital Video Timing-Code Generator

This block produces the word stream of a 625-line, 50 Hz interlaced component video link: an 8-bit multiplexed stream of chroma and luma samples in Cb, Y, Cr, Y order. It is the timing master for the stream. It keeps a word position within the line and a line number from 1 to 625. From the line number it works out the field and vertical-blanking flags. At two fixed places on every line it inserts a four-word timing reference code: an end-of-active-video code at the start of the line and a start-of-active-video code just before the picture area.

On picture lines it asks an upstream pixel source for one word per clock through a ready/valid handshake. It passes each accepted word to the output, after forcing the two reserved values out of the picture range. At every other word position it emits the neutral-chroma, black-luma blanking pattern. If the source has no word ready when one is requested, the generator emits a blanking word in that slot and the stream does not stall.

Line length, horizontal blanking width, active width and the line boundaries of each field are parameters. Their defaults describe the standard 1728-word, 625-line raster at a 27 MHz word clock.

Top module: `vid625_timing_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the generator moves to word 0 of line 1. Word 0 of line 1 appears on `vid_data` as 0xFF with `line_no`=1, `fld`=0 and `vblk`=1, and stays there for as long as reset is held.
- R2: Each line is LINE_WORDS words long, laid out as follows:
  - word positions 0..3 carry the end code 0xFF, 0x00, 0x00, XY;
  - positions 4 to HBLANK_WORDS+3 are horizontal blanking;
  - positions HBLANK_WORDS+4 to HBLANK_WORDS+7 carry the start code 0xFF, 0x00, 0x00, XY;
  - the remaining words form the active region;
  - `hblk` is 1 at every position before the active region and 0 inside it.
- R3: The XY word has the form {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 written first. H is 1 in the end code and 0 in the start code. F and V are the flags of the current line.
- R4: The flags follow the line number:
  - lines 1–22 have F=0, V=1;
  - lines 23–310 have F=0, V=0;
  - lines 311–312 have F=0, V=1;
  - lines 313–335 have F=1, V=1;
  - lines 336–623 have F=1, V=0;
  - lines 624–625 have F=1, V=1;
  - `fld` shows F and `vblk` shows V.
- R5: `line_no` advances by one after the last word of a line and goes from 625 back to 1.
- R6: Every blanking word, in the horizontal blanking region and in the active region of a V=1 line, is 0x80 at an even word position and 0x10 at an odd one.
- R7: `pix_ready` is 1 exactly on the active-region words of V=0 lines. In such a word, with `pix_valid`=1, the input word is consumed and appears on `vid_data` in the same cycle.
- R8: A consumed pixel word of 0x00 is output as 0x01 and one of 0xFF as 0xFE; all other values pass unchanged.
- R9: A word requested while `pix_valid` is 0 is output as the blanking value for its position (see R6), and the stream continues without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_data | input | 8 | Upstream pixel word (Cb/Y/Cr/Y order) |
| pix_valid | input | 1 | Upstream word available |
| pix_ready | output | 1 | Generator consumes a pixel word this cycle |
| vid_data | output | 8 | Output video word stream |
| line_no | output | 10 | Current line number, 1..625 |
| fld | output | 1 | Field flag F of the current line |
| vblk | output | 1 | Vertical blanking flag V of the current line |
| hblk | output | 1 | High outside the active region of the line |

## Verification
The outputs are decoded directly from the two counters, so a wrong word position shows up on `vid_data` in the same cycle. It appears as a misplaced 0xFF preamble or a blanking parity that is flipped. A line counter that skips or fails to wrap shows within one line as a `line_no` step other than +1 or 625→1. A wrong field boundary shows as an XY word with the wrong F or V bits, or as `pix_ready` rising on a blanking line. The bench uses a short line and sweeps more than a full 625-line frame plus the wrap. It compares every output word against values computed from the line and word arithmetic.

// File: rtl/vid625_pkg.sv
// Shared constants and helper functions for the 625-line timing-code generator.
// Assumes 8-bit words; the reference-code preamble uses the two reserved values.
package vid625_pkg;

    localparam logic [7:0] PREAMBLE_HI = 8'hFF;
    localparam logic [7:0] PREAMBLE_LO = 8'h00;
    localparam logic [7:0] BLANK_CHROMA = 8'h80;
    localparam logic [7:0] BLANK_LUMA = 8'h10;

    // Region of a line that a word position falls in
    typedef enum logic [1:0] {
        SEG_END_CODE,
        SEG_HBLANK,
        SEG_START_CODE,
        SEG_ACTIVE
    } seg_e;

    // Status word with protection bits
    function automatic logic [7:0] status_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // Keep picture samples out of the reserved preamble values
    function automatic logic [7:0] clip_sample(input logic [7:0] d);
        if (d == 8'h00) begin
            return 8'h01;
        end else if (d == 8'hFF) begin
            return 8'hFE;
        end
        return d;
    endfunction

endpackage

// File: rtl/vid625_hcount.sv
// Word-position counter within one line.
// Counts 0..LINE_WORDS-1 and flags the last word so the line counter can advance.
// Assumes a synchronous active-low reset to word 0.
module vid625_hcount #(
    parameter int LINE_WORDS = 1728,
    localparam int HW = $clog2(LINE_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic          line_end
);

    // Last word of the line
    always_comb line_end = (hcnt == HW'(LINE_WORDS - 1));

    // Advance the word position, wrapping at the end of the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

endmodule

// File: rtl/vid625_lcount.sv
// Line counter 1..TOTAL_LINES with field and vertical-blanking decode.
// Assumes the boundary parameters are ordered ascending within TOTAL_LINES.
module vid625_lcount #(
    parameter int TOTAL_LINES   = 625,
    parameter int F1_ACT_FIRST  = 23,
    parameter int F1_ACT_LAST   = 310,
    parameter int F2_FIRST      = 313,
    parameter int F2_ACT_FIRST  = 336,
    parameter int F2_ACT_LAST   = 623,
    localparam int LW = $clog2(TOTAL_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [LW-1:0] line_no,
    output logic          fld,
    output logic          vblk
);

    logic in_act1;
    logic in_act2;

    // Advance the line on the last word, wrapping back to line 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_no <= LW'(1);
        end else if (advance) begin
            if (line_no == LW'(TOTAL_LINES)) begin
                line_no <= LW'(1);
            end else begin
                line_no <= line_no + 1'b1;
            end
        end
    end

    // Decode the field and vertical-blanking flags from the line number
    always_comb begin
        in_act1 = (line_no >= LW'(F1_ACT_FIRST)) && (line_no <= LW'(F1_ACT_LAST));
        in_act2 = (line_no >= LW'(F2_ACT_FIRST)) && (line_no <= LW'(F2_ACT_LAST));
        fld     = (line_no >= LW'(F2_FIRST));
        vblk    = !(in_act1 || in_act2);
    end

endmodule

// File: rtl/vid625_wordmux.sv
// Output word selection: reference codes, blanking pattern or clipped pixel data.
// Assumes HBLANK_WORDS is a multiple of 4, so each code starts on a 4-word boundary.
module vid625_wordmux
    import vid625_pkg::*;
#(
    parameter int LINE_WORDS   = 1728,
    parameter int HBLANK_WORDS = 280,
    localparam int HW = $clog2(LINE_WORDS),
    localparam int SAV_POS = HBLANK_WORDS + 4,
    localparam int ACT_POS = HBLANK_WORDS + 8
) (
    input  logic [HW-1:0] hcnt,
    input  logic          fld,
    input  logic          vblk,
    input  logic [7:0]    pix_data,
    input  logic          pix_valid,
    output logic          pix_ready,
    output logic          hblk,
    output logic [7:0]    vid_data
);

    seg_e       seg;
    logic [7:0] blank_word;
    logic [7:0] code_word;

    if (HBLANK_WORDS % 4 != 0) begin : g_bad_hblank
        $error("HBLANK_WORDS must be a multiple of 4");
    end

    // Classify the word position into a line region
    always_comb begin
        if (hcnt < HW'(4)) begin
            seg = SEG_END_CODE;
        end else if (hcnt < HW'(SAV_POS)) begin
            seg = SEG_HBLANK;
        end else if (hcnt < HW'(ACT_POS)) begin
            seg = SEG_START_CODE;
        end else begin
            seg = SEG_ACTIVE;
        end
    end

    // Blanking word by sample parity, and the code word by position in the code
    always_comb begin
        blank_word = hcnt[0] ? BLANK_LUMA : BLANK_CHROMA;
        unique case (hcnt[1:0])
            2'd0:    code_word = PREAMBLE_HI;
            2'd3:    code_word = status_word(fld, vblk, seg == SEG_END_CODE);
            default: code_word = PREAMBLE_LO;
        endcase
    end

    // Select the output word and request pixels on picture words
    always_comb begin
        hblk      = (seg != SEG_ACTIVE);
        pix_ready = (seg == SEG_ACTIVE) && !vblk;
        unique case (seg)
            SEG_END_CODE, SEG_START_CODE: vid_data = code_word;
            SEG_ACTIVE: vid_data = (pix_ready && pix_valid) ? clip_sample(pix_data) : blank_word;
            default:    vid_data = blank_word;
        endcase
    end

endmodule

// File: rtl/vid625_timing_gen.sv
// Top of the 625-line timing-code generator.
// Connects the word counter, the line counter and the output word selector.
// Assumes one output word per clock and a synchronous active-low reset.
module vid625_timing_gen #(
    parameter int HBLANK_WORDS  = 280,
    parameter int ACTIVE_WORDS  = 1440,
    parameter int TOTAL_LINES   = 625,
    parameter int F1_ACT_FIRST  = 23,
    parameter int F1_ACT_LAST   = 310,
    parameter int F2_FIRST      = 313,
    parameter int F2_ACT_FIRST  = 336,
    parameter int F2_ACT_LAST   = 623,
    localparam int LINE_WORDS = HBLANK_WORDS + ACTIVE_WORDS + 8,
    localparam int HW = $clog2(LINE_WORDS),
    localparam int LW = $clog2(TOTAL_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    pix_data,
    input  logic          pix_valid,
    output logic          pix_ready,
    output logic [7:0]    vid_data,
    output logic [LW-1:0] line_no,
    output logic          fld,
    output logic          vblk,
    output logic          hblk
);

    logic [HW-1:0] hcnt;
    logic          line_end;

    vid625_hcount #(.LINE_WORDS(LINE_WORDS)) u_hcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .hcnt     (hcnt),
        .line_end (line_end)
    );

    vid625_lcount #(
        .TOTAL_LINES  (TOTAL_LINES),
        .F1_ACT_FIRST (F1_ACT_FIRST),
        .F1_ACT_LAST  (F1_ACT_LAST),
        .F2_FIRST     (F2_FIRST),
        .F2_ACT_FIRST (F2_ACT_FIRST),
        .F2_ACT_LAST  (F2_ACT_LAST)
    ) u_lcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (line_end),
        .line_no (line_no),
        .fld     (fld),
        .vblk    (vblk)
    );

    vid625_wordmux #(
        .LINE_WORDS   (LINE_WORDS),
        .HBLANK_WORDS (HBLANK_WORDS)
    ) u_wordmux (
        .hcnt      (hcnt),
        .fld       (fld),
        .vblk      (vblk),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .hblk      (hblk),
        .vid_data  (vid_data)
    );

endmodule

// File: rtl/vid625_timing_chk.sv
// Property checker for the 625-line timing-code generator, bound to the top.
// Assumes the bound instance exposes its end-of-line strobe as line_end.
module vid625_timing_chk #(
    parameter int TOTAL_LINES  = 625,
    parameter int F2_FIRST     = 313,
    parameter int F1_ACT_FIRST = 23,
    parameter int F2_ACT_FIRST = 336,
    localparam int LW = $clog2(TOTAL_LINES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_end,
    input logic [LW-1:0] line_no,
    input logic          fld,
    input logic          vblk,
    input logic          pix_ready,
    input logic [7:0]    vid_data
);

    // Line number stays in range
    assert_line_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_no >= LW'(1)) && (line_no <= LW'(TOTAL_LINES)));

    // Last line wraps to line 1
    assert_line_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && line_no == LW'(TOTAL_LINES)) |=> (line_no == LW'(1)));

    // Other lines step by one
    assert_line_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && line_no != LW'(TOTAL_LINES)) |=> (line_no == $past(line_no) + 1'b1));

    // Line holds within a line
    assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(line_no));

    // Field flag changes only at the field boundaries
    assert_field_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fld) |-> (line_no == LW'(F2_FIRST)));

    assert_field_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fld) |-> (line_no == LW'(1)));

    // Active video begins only on the first picture line of a field
    assert_vblank_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblk) |-> (line_no == LW'(F1_ACT_FIRST) || line_no == LW'(F2_ACT_FIRST)));

    // No pixel requests on blanking lines
    assert_no_req_in_vblank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> !vblk);

    // Picture words never carry reserved values
    assert_no_reserved_pixel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> (vid_data != 8'h00 && vid_data != 8'hFF));

endmodule

bind vid625_timing_gen vid625_timing_chk #(
    .TOTAL_LINES  (TOTAL_LINES),
    .F2_FIRST     (F2_FIRST),
    .F1_ACT_FIRST (F1_ACT_FIRST),
    .F2_ACT_FIRST (F2_ACT_FIRST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_end  (line_end),
    .line_no   (line_no),
    .fld       (fld),
    .vblk      (vblk),
    .pix_ready (pix_ready),
    .vid_data  (vid_data)
);

// File: tb/vid625_timing_gen_tb.sv
// Sweeps a full 625-line frame plus the wrap on a short line, then a mid-stream reset.
module vid625_timing_gen_tb;

    localparam int HB = 8;
    localparam int ACT = 16;
    localparam int LWORDS = HB + ACT + 8;
    localparam int NLINES = 625;
    localparam int SWEEP = LWORDS * NLINES + 3 * LWORDS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic       pix_valid = 1'b0;
    logic       pix_ready;
    logic [7:0] vid_data;
    logic [9:0] line_no;
    logic       fld;
    logic       vblk;
    logic       hblk;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vid625_timing_gen #(.HBLANK_WORDS(HB), .ACTIVE_WORDS(ACT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_data  (pix_data),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .vid_data  (vid_data),
        .line_no   (line_no),
        .fld       (fld),
        .vblk      (vblk),
        .hblk      (hblk)
    );

    task automatic chk(input string req, input int act, input int exp, input int n);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at word %0d", req, act, exp, n);
        end
    endtask

    function automatic int blank_of(input int h);
        return (h % 2 == 0) ? 8'h80 : 8'h10;
    endfunction

    // Drive and check n cycles counted from the current word-0 state
    task automatic run_words(input int count);
        for (int n = 0; n < count; n++) begin
            int h = n % LWORDS;
            int ln = (n / LWORDS) % NLINES + 1;
            int f = (ln >= 313) ? 1 : 0;
            int v = (ln <= 22 || (ln >= 311 && ln <= 335) || ln >= 624) ? 1 : 0;
            int pd = (n * 5 + n / 256) % 256;
            int pv = ((n % 11) != 7) ? 1 : 0;
            int act = (h >= HB + 8) ? 1 : 0;
            int rdy = (act == 1 && v == 0) ? 1 : 0;
            int hh;
            int xy;
            int exp;
            pix_data = 8'(pd);
            pix_valid = pv[0];
            #1;
            chk("R5 line_no", int'(line_no), ln, n);
            chk("R4 fld", int'(fld), f, n);
            chk("R4 vblk", int'(vblk), v, n);
            chk("R2 hblk", int'(hblk), 1 - act, n);
            chk("R7 pix_ready", int'(pix_ready), rdy, n);
            if (h < 4 || (h >= HB + 4 && h < HB + 8)) begin
                hh = (h < 4) ? 1 : 0;
                xy = 128 + f * 64 + v * 32 + hh * 16 + ((v ^ hh) * 8) + ((f ^ hh) * 4)
                     + ((f ^ v) * 2) + (f ^ v ^ hh);
                case (h % 4)
                    0: chk("R2 preamble", int'(vid_data), 8'hFF, n);
                    3: chk("R3 xy word", int'(vid_data), xy, n);
                    default: chk("R2 preamble", int'(vid_data), 8'h00, n);
                endcase
            end else if (rdy == 0) begin
                chk("R6 blanking", int'(vid_data), blank_of(h), n);
            end else if (pv == 0) begin
                chk("R9 underflow", int'(vid_data), blank_of(h), n);
            end else if (pd == 0 || pd == 255) begin
                exp = (pd == 0) ? 1 : 254;
                chk("R8 clip", int'(vid_data), exp, n);
            end else begin
                chk("R7 pixel pass", int'(vid_data), pd, n);
            end
            @(negedge clk);
        end
    endtask

    task automatic chk_reset_state();
        chk("R1 reset vid_data", int'(vid_data), 8'hFF, -1);
        chk("R1 reset line_no", int'(line_no), 1, -1);
        chk("R1 reset fld", int'(fld), 0, -1);
        chk("R1 reset vblk", int'(vblk), 1, -1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_reset_state();
        rst_n = 1'b1;
        run_words(SWEEP);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_reset_state();
        rst_n = 1'b1;
        run_words(3 * LWORDS);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule